// File: doc/BRIEF.md
# Systematic Reed-Solomon LFSR Encoder

This block turns a stream of message symbols into systematic Reed-Solomon codewords over GF(2^M). Each symbol is M bits wide. A codeword holds N = 2^M - 1 symbols: K = N - 2T message symbols followed by 2T check symbols. The message symbols are accepted one per clock on a valid/ready input, highest polynomial power first. They are copied to the output one cycle later. While they pass through, a bank of 2T parity registers divides the shifted message by the generator polynomial. The divider is a linear feedback shift register whose feedback taps are constant Galois-field multipliers, each built as a plain XOR network.

A start marker on the first symbol opens a codeword. After the K-th symbol the block stops accepting input. The feedback is then held at zero, so the remainder shifts out of the top register one symbol per clock. A flag marks the last check symbol. The field polynomial and the generator roots are fixed at elaboration, so the tap constants and the multiplier networks are computed at that point and cost no run-time logic.

Top module: `rs_lfsr_encoder`

## Requirements
- R1: While reset is high and on the cycle after it, `out_valid` and `out_eoc` are low and `in_ready` is high.
- R2: Each message symbol accepted on a clock edge appears on `out_data` with `out_valid` high and `out_is_parity` low right after that edge. The symbols keep their order and are unchanged.
- R3: The 2T symbols after the K message symbols are the remainder of m(x)·x^(2T) divided by g(x), highest power first, with `out_is_parity` high. The field is built on x^8+x^4+x^3+x^2+1 (0x11D), α is 2, and g(x) has the roots α^0 to α^(2T-1).
- R4: Every output codeword, read highest power first, evaluates to zero at each of α^0 to α^(2T-1).
- R5: After the edge that accepts the K-th message symbol, `in_ready` stays low for exactly 2T cycles. The check symbols leave on consecutive clocks with no gap.
- R6: `out_eoc` is high only together with the 2T-th check symbol of a codeword, once per codeword.
- R7: A new codeword can open with `in_sop` on the clock right after the last check symbol. Its check symbols depend only on its own message, with no carry-over from the previous codeword.
- R8: When no codeword is open, input symbols presented without `in_sop` are dropped. They produce no output and leave the next codeword's check symbols unchanged.
- R9: `in_sop` raised during the message phase has no effect. The symbol with it is treated as ordinary message data.
- R10: Cycles with `in_valid` low inside the message phase produce no output and do not change the resulting codeword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input symbol present |
| in_sop | input | 1 | Marks the first message symbol of a codeword |
| in_data | input | M | Message symbol |
| in_ready | output | 1 | Encoder can take a symbol |
| out_valid | output | 1 | Output symbol present |
| out_data | output | M | Message or check symbol |
| out_is_parity | output | 1 | Output symbol is a check symbol |
| out_eoc | output | 1 | Last check symbol of the codeword |

## Verification
The bench uses the default parameters M = 8 and T = 8, which give the full-length 255-symbol code with 16 check symbols. At this size all sixteen XOR-network multipliers, the longest feedback chain and the 239-symbol message counter are exercised on every codeword. Random messages with random bubbles are mixed with all-zero and all-ones messages, back-to-back codewords, dropped idle symbols and a stray start marker. Each codeword is checked against a long-division model and by evaluating it at the sixteen generator roots.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MSG   = 2'd1,
        ST_FLUSH = 2'd2
    } enc_state_e;

    // side-band tags travelling with each output symbol
    typedef struct packed {
        logic valid;
        logic parity;
        logic last;
    } sym_tag_t;

    // product of two field elements; poly includes the x^m term
    function automatic int gf_mul(input int a, input int b, input int m, input int poly);
        int acc;
        int x;
        acc = 0;
        x   = a;
        for (int i = 0; i < m; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x << 1;
            if ((x & (1 << m)) != 0) x = x ^ poly;
        end
        return acc;
    endfunction

    // alpha = 2 raised to e
    function automatic int gf_alpha_pow(input int e, input int m, input int poly);
        int x;
        x = 1;
        for (int i = 0; i < e; i++) x = gf_mul(x, 2, m, poly);
        return x;
    endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul #(
    parameter int M    = 8,
    parameter int POLY = 'h11D,
    parameter int COEF = 1
) (
    input  logic [M-1:0] sym,
    output logic [M-1:0] prod
);
    import rs_enc_pkg::*;

    // row j selects the input bits that feed output bit j
    function automatic logic [M*M-1:0] build_masks();
        logic [M*M-1:0] mk;
        int col;
        mk = '0;
        for (int b = 0; b < M; b++) begin
            col = gf_mul(COEF, 1 << b, M, POLY);
            for (int j = 0; j < M; j++) mk[j*M + b] = col[j];
        end
        return mk;
    endfunction

    localparam logic [M*M-1:0] MASKS = build_masks();

    for (genvar j = 0; j < M; j++) begin : g_bit
        assign prod[j] = ^(sym & MASKS[j*M +: M]);
    end

endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr #(
    parameter int M    = 8,
    parameter int T    = 8,
    parameter int POLY = 'h11D
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         clear,
    input  logic         feed_en,
    input  logic [M-1:0] din,
    output logic [M-1:0] top_sym
);
    import rs_enc_pkg::*;

    localparam int NPAR = 2 * T;

    // coefficients g0..g(NPAR-1) of the monic generator
    function automatic logic [NPAR*M-1:0] gen_taps();
        int c [0:NPAR];
        int root;
        logic [NPAR*M-1:0] r;
        for (int i = 0; i <= NPAR; i++) c[i] = 0;
        c[0] = 1;
        for (int i = 0; i < NPAR; i++) begin
            root = gf_alpha_pow(i, M, POLY);
            for (int j = i + 1; j >= 0; j--) begin
                if (j > 0) c[j] = c[j-1] ^ gf_mul(c[j], root, M, POLY);
                else       c[j] = gf_mul(c[j], root, M, POLY);
            end
        end
        r = '0;
        for (int j = 0; j < NPAR; j++) r[j*M +: M] = M'(c[j]);
        return r;
    endfunction

    localparam logic [NPAR*M-1:0] TAPS = gen_taps();

    logic [M-1:0] stage [NPAR];
    logic [M-1:0] base  [NPAR];
    logic [M-1:0] prod  [NPAR];
    logic [M-1:0] fb;

    always_comb begin
        for (int i = 0; i < NPAR; i++) base[i] = clear ? '0 : stage[i];
        fb = feed_en ? (din ^ base[NPAR-1]) : '0;
    end

    for (genvar i = 0; i < NPAR; i++) begin : g_tap
        rs_gf_cmul #(
            .M   (M),
            .POLY(POLY),
            .COEF(int'(TAPS[i*M +: M]))
        ) u_mul (
            .sym (fb),
            .prod(prod[i])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                stage[i] <= '0;
            end else if (shift_en) begin
                if (i == 0) stage[i] <= prod[i];
                else        stage[i] <= base[(i > 0) ? i - 1 : 0] ^ prod[i];
            end
        end
    end

    assign top_sym = stage[NPAR-1];

endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl #(
    parameter int K    = 239,
    parameter int NPAR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sop,
    output logic in_ready,
    output logic msg_take,
    output logic first,
    output logic flushing,
    output logic last_par
);
    import rs_enc_pkg::*;

    localparam int CMAX = (K > NPAR) ? K : NPAR;
    localparam int CW   = $clog2(CMAX + 1);

    enc_state_e    state;
    logic [CW-1:0] cnt;

    assign in_ready = (state != ST_FLUSH);
    assign msg_take = in_valid && (((state == ST_IDLE) && in_sop) || (state == ST_MSG));
    assign first    = msg_take && (state == ST_IDLE);
    assign flushing = (state == ST_FLUSH);
    assign last_par = flushing && (cnt == CW'(NPAR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (first) begin
                        state <= ST_MSG;
                        cnt   <= CW'(1);
                    end
                end
                ST_MSG: begin
                    if (msg_take) begin
                        if (cnt == CW'(K - 1)) begin
                            state <= ST_FLUSH;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (last_par) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rs_lfsr_encoder.sv
module rs_lfsr_encoder #(
    parameter int M    = 8,
    parameter int T    = 8,
    parameter int POLY = 'h11D
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_sop,
    input  logic [M-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [M-1:0] out_data,
    output logic         out_is_parity,
    output logic         out_eoc
);
    import rs_enc_pkg::*;

    localparam int N    = (1 << M) - 1;
    localparam int NPAR = 2 * T;
    localparam int K    = N - NPAR;

    logic         msg_take;
    logic         first;
    logic         flushing;
    logic         last_par;
    logic [M-1:0] par_sym;
    sym_tag_t     tag_q;
    logic [M-1:0] data_q;

    rs_enc_ctrl #(
        .K   (K),
        .NPAR(NPAR)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_sop  (in_sop),
        .in_ready(in_ready),
        .msg_take(msg_take),
        .first   (first),
        .flushing(flushing),
        .last_par(last_par)
    );

    rs_parity_lfsr #(
        .M   (M),
        .T   (T),
        .POLY(POLY)
    ) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .shift_en(msg_take || flushing),
        .clear   (first),
        .feed_en (msg_take),
        .din     (in_data),
        .top_sym (par_sym)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            data_q <= '0;
        end else begin
            tag_q.valid  <= msg_take || flushing;
            tag_q.parity <= flushing;
            tag_q.last   <= last_par;
            if (msg_take)      data_q <= in_data;
            else if (flushing) data_q <= par_sym;
        end
    end

    assign out_valid     = tag_q.valid;
    assign out_is_parity = tag_q.parity;
    assign out_eoc       = tag_q.last;
    assign out_data      = data_q;

endmodule

// File: rtl/rs_lfsr_encoder_chk.sv
module rs_lfsr_encoder_chk #(
    parameter int M    = 8,
    parameter int NPAR = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [M-1:0] in_data,
    input logic         in_ready,
    input logic         out_valid,
    input logic [M-1:0] out_data,
    input logic         out_is_parity,
    input logic         out_eoc
);
    localparam int PW = $clog2(NPAR + 1);

    logic [PW-1:0] par_cnt;

    always_ff @(posedge clk) begin
        if (rst)                              par_cnt <= '0;
        else if (out_eoc)                     par_cnt <= '0;
        else if (out_valid && out_is_parity)  par_cnt <= par_cnt + 1'b1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_eoc && in_ready));

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_parity) |-> ($past(in_valid && in_ready) && out_data == $past(in_data)));

    // R5
    ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_parity && !out_eoc) |-> !in_ready);

    // R5
    par_run_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_parity && !out_eoc) |=> (out_valid && out_is_parity));

    // R6
    eoc_tag_chk: assert property (@(posedge clk) disable iff (rst)
        out_eoc |-> (out_valid && out_is_parity && par_cnt == PW'(NPAR - 1)));

    // R7
    reopen_chk: assert property (@(posedge clk) disable iff (rst)
        out_eoc |-> in_ready);

endmodule

bind rs_lfsr_encoder rs_lfsr_encoder_chk #(
    .M   (M),
    .NPAR(2 * T)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_is_parity(out_is_parity),
    .out_eoc      (out_eoc)
);

// File: tb/rs_lfsr_encoder_test.sv
`timescale 1ns/1ps
module rs_lfsr_encoder_test;
    localparam int M    = 8;
    localparam int T    = 8;
    localparam int POLY = 'h11D;
    localparam int N    = (1 << M) - 1;
    localparam int NPAR = 2 * T;
    localparam int K    = N - NPAR;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_sop = 1'b0;
    logic [M-1:0] in_data = '0;
    logic         in_ready;
    logic         out_valid;
    logic [M-1:0] out_data;
    logic         out_is_parity;
    logic         out_eoc;

    int checks = 0;
    int errors = 0;

    int msg  [0:K-1];
    int got  [0:N-1];
    int gotp [0:N-1];
    int gote [0:N-1];
    int widx = 0;
    int gpoly [0:NPAR];

    always #5 clk = ~clk;

    rs_lfsr_encoder #(.M(M), .T(T), .POLY(POLY)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_is_parity(out_is_parity), .out_eoc(out_eoc)
    );

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (widx < N) begin
                got[widx]  = int'(out_data);
                gotp[widx] = int'(out_is_parity);
                gote[widx] = int'(out_eoc);
            end
            widx = widx + 1;
        end
    end

    function automatic int fmul(input int a, input int b);
        int r;
        int aa;
        int bb;
        r = 0; aa = a; bb = b;
        while (bb != 0) begin
            if ((bb & 1) != 0) r = r ^ aa;
            bb = bb >> 1;
            aa = aa << 1;
            if (aa >= (1 << M)) aa = aa ^ POLY;
        end
        return r;
    endfunction

    function automatic int fpow(input int e);
        int r;
        r = 1;
        for (int i = 0; i < e; i++) r = fmul(r, 2);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic build_gen();
        int nc [0:NPAR];
        for (int i = 0; i <= NPAR; i++) gpoly[i] = 0;
        gpoly[0] = 1;
        for (int i = 0; i < NPAR; i++) begin
            int r;
            r = fpow(i);
            for (int j = 0; j <= NPAR; j++) nc[j] = fmul(gpoly[j], r);
            for (int j = 1; j <= NPAR; j++) nc[j] = nc[j] ^ gpoly[j-1];
            for (int j = 0; j <= NPAR; j++) gpoly[j] = nc[j];
        end
    endtask

    // long division of m(x)*x^NPAR by g(x); returns remainder coefficient by power
    task automatic model_rem(output int rem [0:NPAR-1]);
        int u [0:N-1];
        for (int p = 0; p < N; p++) u[p] = 0;
        for (int i = 0; i < K; i++) u[N-1-i] = msg[i];
        for (int p = N - 1; p >= NPAR; p--) begin
            int q;
            q = u[p];
            if (q != 0)
                for (int j = 0; j <= NPAR; j++) u[p-NPAR+j] = u[p-NPAR+j] ^ fmul(q, gpoly[j]);
        end
        for (int j = 0; j < NPAR; j++) rem[j] = u[j];
    endtask

    // mode: 0 random, 1 zeros, 2 all ones; gap: percent bubble chance; sop_mid: stray marker
    task automatic send_cw(input int mode, input int gap, input bit sop_mid, input string tag);
        int rem [0:NPAR-1];
        int lows;
        int bad;
        int badv;
        int expv;
        for (int i = 0; i < K; i++) begin
            if (mode == 1)      msg[i] = 0;
            else if (mode == 2) msg[i] = (1 << M) - 1;
            else                msg[i] = int'($urandom_range((1 << M) - 1, 0));
        end
        widx = 0;
        for (int i = 0; i < K; i++) begin
            while (gap > 0 && int'($urandom_range(99, 0)) < gap) begin
                in_valid = 1'b0;
                in_sop   = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_data  = M'(msg[i]);
            in_sop   = (i == 0) || (sop_mid && i == K / 2);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        lows = 0;
        for (int c = 0; c < NPAR; c++) begin
            @(negedge clk);
            if (!in_ready) lows++;
        end
        check(lows == NPAR, {"R5 ready low ", tag}, lows, NPAR);
        @(negedge clk);
        check(in_ready == 1'b1, {"R7 ready back ", tag}, int'(in_ready), 1);
        #1;
        check(widx == N, {"R10 symbol count ", tag}, widx, N);
        model_rem(rem);
        bad = -1; badv = 0; expv = 0;
        for (int i = 0; i < K; i++)
            if (bad < 0 && (got[i] != msg[i] || gotp[i] != 0)) begin bad = i; badv = got[i]; expv = msg[i]; end
        check(bad < 0, {"R2 passthrough ", tag}, badv, expv);
        bad = -1;
        for (int j = 0; j < NPAR; j++)
            if (bad < 0 && (got[K+j] != rem[NPAR-1-j] || gotp[K+j] != 1)) begin bad = j; badv = got[K+j]; expv = rem[NPAR-1-j]; end
        check(bad < 0, {"R3 parity ", tag}, badv, expv);
        bad = -1;
        for (int i = 0; i < N; i++)
            if (bad < 0 && gote[i] != ((i == N - 1) ? 1 : 0)) begin bad = i; badv = gote[i]; end
        check(bad < 0, {"R6 eoc position ", tag}, bad, -1);
        bad = -1; badv = 0;
        for (int r = 0; r < NPAR; r++) begin
            int s;
            int a;
            s = 0;
            a = fpow(r);
            for (int i = 0; i < N; i++) s = fmul(s, a) ^ got[i];
            if (bad < 0 && s != 0) begin bad = r; badv = s; end
        end
        check(bad < 0, {"R4 syndrome ", tag}, badv, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        repeat (145000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        int seen;
        int rdy_low;
        seed = $urandom(32'd20240607);
        build_gen();
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_eoc == 1'b0, "R1 outputs in reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", int'(out_valid), 0);

        // R8: symbols without a start marker while idle
        widx = 0;
        rdy_low = 0;
        @(posedge clk); #1;
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1;
            in_sop   = 1'b0;
            in_data  = M'(int'($urandom_range(255, 1)));
            @(negedge clk);
            if (!in_ready) rdy_low++;
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        @(negedge clk);
        seen = widx;
        check(seen == 0, "R8 idle symbols dropped", seen, 0);
        check(rdy_low == 0, "R8 ready held while idle", rdy_low, 0);
        @(posedge clk); #1;
        send_cw(0, 0, 1'b0, "after idle junk R8");

        // corner messages, back to back (R7)
        send_cw(1, 0, 1'b0, "zeros R7");
        send_cw(2, 0, 1'b0, "ones R7");
        send_cw(0, 0, 1'b0, "random after ones R7");

        // R9: stray start marker mid message
        send_cw(0, 0, 1'b1, "mid sop R9");

        // R10: bubbles in the input stream
        send_cw(0, 30, 1'b0, "bubbles R10");
        send_cw(2, 50, 1'b0, "ones bubbles R10");

        for (int n = 0; n < 8; n++) begin
            send_cw(0, (n % 2 == 0) ? 0 : 15, 1'b0, "random");
            if (n % 3 == 0) begin
                repeat (int'($urandom_range(4, 0))) @(posedge clk);
                #1;
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule